// File: doc/BRIEF.md
# Reset Pin Sequencer with Cause Capture

This block controls a shared, bidirectional open-drain reset line. Any reset request stretches the line low for a fixed number of reset-clock cycles. The requests come from power-on, low-voltage detection, the watchdog, or an outside agent pulling the line low. After that interval the block lets go of the line and waits a second fixed interval. It then reads the line back through a synchronizer. A high reading ends the sequence. A low reading means something outside is still holding the line, so the block stays in reset, marks the cause as an external pin reset, and reads again after each further wait interval.

The block keeps a one-hot status word that names the cause of the most recent reset. It drives a system reset output that covers the whole sequence plus one output register stage. When the reset is released, it captures a boot-mode input: a low level selects debug (background) mode and a high level selects normal operation. Power-on is the block's asynchronous reset input, so it always wins and always starts a fresh sequence.

Top module: `rstseq_top`

## Requirements
- R1: After power-on or any accepted request, `pin_drive_low` is high for exactly DRIVE_CYC consecutive clock cycles and then goes low.
- R2: The line is sampled on the SAMPLE_CYC-th rising edge after the drive ends. A high sample ends the sequence, so `sys_rst` falls SAMPLE_CYC+1 cycles after `pin_drive_low` falls.
- R3: While idle, a low-voltage or watchdog request seen on a rising edge makes `pin_drive_low` high from that edge onward.
- R4: While idle, a low level on `pin_in` starts a sequence SYNC_STAGES+1 rising edges after it appears, and is recorded as an external pin reset.
- R5: `rst_cause` always has exactly one bit set. The bits are: bit 0 power-on, bit 1 low-voltage, bit 2 watchdog, bit 3 external pin.
- R6: When several requests are seen on the same edge, low-voltage beats watchdog and watchdog beats external pin. Power-on beats all of them.
- R7: If the post-release sample reads low, `sys_rst` stays high and `rst_cause` becomes bit 3. The line is sampled again every SAMPLE_CYC cycles until it reads high.
- R8: `sys_rst` is high during power-on. It rises one cycle after a sequence starts and stays high until one cycle after the good high sample.
- R9: `debug_mode` takes the inverse of `mode_sel_in` on the edge that ends the sequence, so it is 1 when the input was low. Changes of `mode_sel_in` at other times have no effect on it.
- R10: Low-voltage, watchdog and pin requests that arrive during a sequence are ignored. They change neither its timing nor `rst_cause`.
- R11: While `por_n` is low, the outputs are `pin_drive_low`=1, `sys_rst`=1, `rst_cause`=4'b0001 and `debug_mode`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dedicated reset clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| lvd_req | input | 1 | Low-voltage reset request, synchronous |
| wdog_req | input | 1 | Watchdog reset request, synchronous |
| pin_in | input | 1 | Sensed level of the reset line, asynchronous |
| mode_sel_in | input | 1 | Boot-mode select, low = debug mode |
| pin_drive_low | output | 1 | 1 = pull the reset line low |
| sys_rst | output | 1 | System reset, active high |
| rst_cause | output | 4 | One-hot cause of the last reset |
| debug_mode | output | 1 | Mode captured at release, 1 = debug |

## Verification
Some properties are checked on every cycle:
- the cause word is always one-hot;
- the drive-low stretch always has exactly the configured length;
- the wait before each sample always has exactly the configured length;
- an idle request always starts a drive on the next cycle;
- `sys_rst` always covers the drive;
- the cause is frozen while the line is driven;
- the captured mode holds while the system runs.

Other behaviours only the bench scenarios show:
- the end-to-end release timing;
- the synchronizer latency of an external pull-down;
- the cause priority under simultaneous requests;
- repeated sampling under a prolonged external hold, and the captured mode values.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

   typedef enum logic [1:0] {
      ST_RUN   = 2'd0,
      ST_DRIVE = 2'd1,
      ST_WAIT  = 2'd2
   } seq_state_e;

   localparam int CAUSE_W    = 4;
   localparam int CAUSE_POR  = 0;
   localparam int CAUSE_LVD  = 1;
   localparam int CAUSE_WDOG = 2;
   localparam int CAUSE_PIN  = 3;

   // Priority encoder: low-voltage > watchdog > external pin.
   function automatic logic [CAUSE_W-1:0] pick_cause(input logic lvd,
                                                     input logic wdog,
                                                     input logic pin_ext);
      logic [CAUSE_W-1:0] c;
      c = '0;
      if (lvd)          c[CAUSE_LVD]  = 1'b1;
      else if (wdog)    c[CAUSE_WDOG] = 1'b1;
      else if (pin_ext) c[CAUSE_PIN]  = 1'b1;
      else              c[CAUSE_POR]  = 1'b1;
      return c;
   endfunction

endpackage

// File: rtl/rstseq_sync.sv
module rstseq_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("rstseq_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/rstseq_cause.sv
module rstseq_cause
   import rstseq_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               capture,
   input  logic               lvd,
   input  logic               wdog,
   input  logic               pin_ext,
   input  logic               mark_pin,
   output logic [CAUSE_W-1:0] cause
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cause <= CAUSE_W'(1) << CAUSE_POR;
      end else if (capture) begin
         cause <= pick_cause(lvd, wdog, pin_ext);
      end else if (mark_pin) begin
         cause <= CAUSE_W'(1) << CAUSE_PIN;
      end
   end

   // R5: status word is one-hot at all times
   p_cause_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(cause) == 1);

   // R7: a failed sample leaves the pin bit as the cause
   p_mark_pin_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mark_pin && !capture) |=> cause[CAUSE_PIN]);
endmodule

// File: rtl/rstseq_seq.sv
module rstseq_seq
   import rstseq_pkg::*;
#(
   parameter int DRIVE_CYC  = 34,
   parameter int SAMPLE_CYC = 38
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic pin_hi,
   output logic drive_low,
   output logic in_run,
   output logic sys_rst,
   output logic release_o,
   output logic bad_sample
);
   localparam int MAX_CYC = (DRIVE_CYC > SAMPLE_CYC) ? DRIVE_CYC : SAMPLE_CYC;
   localparam int CNT_W   = $clog2(MAX_CYC);
   localparam logic [CNT_W-1:0] DRV_LAST = CNT_W'(DRIVE_CYC - 1);
   localparam logic [CNT_W-1:0] SMP_LAST = CNT_W'(SAMPLE_CYC - 1);

   if (DRIVE_CYC < 2 || SAMPLE_CYC < 2) begin : g_bad_len
      $error("rstseq_seq: DRIVE_CYC and SAMPLE_CYC must be at least 2");
   end

   seq_state_e       st, st_n;
   logic [CNT_W-1:0] cnt, cnt_n;

   always_comb begin
      st_n       = st;
      cnt_n      = cnt;
      release_o  = 1'b0;
      bad_sample = 1'b0;
      case (st)
         ST_RUN: begin
            if (start) begin
               st_n  = ST_DRIVE;
               cnt_n = '0;
            end
         end
         ST_DRIVE: begin
            if (cnt == DRV_LAST) begin
               st_n  = ST_WAIT;
               cnt_n = '0;
            end else begin
               cnt_n = cnt + 1'b1;
            end
         end
         ST_WAIT: begin
            if (cnt == SMP_LAST) begin
               cnt_n = '0;
               if (pin_hi) begin
                  st_n      = ST_RUN;
                  release_o = 1'b1;
               end else begin
                  bad_sample = 1'b1;
               end
            end else begin
               cnt_n = cnt + 1'b1;
            end
         end
         default: begin
            st_n  = ST_DRIVE;
            cnt_n = '0;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_DRIVE;
         cnt     <= '0;
         sys_rst <= 1'b1;
      end else begin
         st      <= st_n;
         cnt     <= cnt_n;
         sys_rst <= (st != ST_RUN);
      end
   end

   assign drive_low = (st == ST_DRIVE);
   assign in_run    = (st == ST_RUN);

   // Checker counters, independent of the sequencer counter
   logic [CNT_W:0] drv_seen;
   logic [CNT_W:0] wait_seen;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         drv_seen  <= '0;
         wait_seen <= '0;
      end else begin
         drv_seen  <= drive_low ? drv_seen + 1'b1 : '0;
         wait_seen <= (!drive_low && !in_run && !bad_sample) ? wait_seen + 1'b1 : '0;
      end
   end

   // R1: drive-low stretch has exactly DRIVE_CYC cycles
   p_drive_len_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(drive_low) |-> drv_seen == (CNT_W+1)'(DRIVE_CYC));

   // R2: a release sample happens SAMPLE_CYC cycles into the wait
   p_wait_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
      release_o |-> wait_seen == (CNT_W+1)'(SAMPLE_CYC - 1));

   // R3: an idle request drives the line from the next cycle
   p_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_run && start) |=> drive_low);

   // R8: the system reset covers the drive interval
   p_sysrst_cover_r8: assert property (@(posedge clk) disable iff (!rst_n)
      drive_low |=> sys_rst);
endmodule

// File: rtl/rstseq_top.sv
module rstseq_top
   import rstseq_pkg::*;
#(
   parameter int DRIVE_CYC   = 34,
   parameter int SAMPLE_CYC  = 38,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               por_n,
   input  logic               lvd_req,
   input  logic               wdog_req,
   input  logic               pin_in,
   input  logic               mode_sel_in,
   output logic               pin_drive_low,
   output logic               sys_rst,
   output logic [CAUSE_W-1:0] rst_cause,
   output logic               debug_mode
);
   if (SAMPLE_CYC < SYNC_STAGES + 1) begin : g_bad_sample
      $error("rstseq_top: SAMPLE_CYC must cover the synchronizer latency");
   end

   logic pin_s;
   logic in_run;
   logic release_w;
   logic bad_w;
   logic start_w;
   logic pin_ext;

   rstseq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pin_sync (
      .clk   (clk),
      .rst_n (por_n),
      .d     (pin_in),
      .q     (pin_s)
   );

   assign pin_ext = ~pin_s;
   assign start_w = in_run & (lvd_req | wdog_req | pin_ext);

   rstseq_seq #(.DRIVE_CYC(DRIVE_CYC), .SAMPLE_CYC(SAMPLE_CYC)) u_seq (
      .clk        (clk),
      .rst_n      (por_n),
      .start      (start_w),
      .pin_hi     (pin_s),
      .drive_low  (pin_drive_low),
      .in_run     (in_run),
      .sys_rst    (sys_rst),
      .release_o  (release_w),
      .bad_sample (bad_w)
   );

   rstseq_cause u_cause (
      .clk      (clk),
      .rst_n    (por_n),
      .capture  (start_w),
      .lvd      (lvd_req),
      .wdog     (wdog_req),
      .pin_ext  (pin_ext),
      .mark_pin (bad_w),
      .cause    (rst_cause)
   );

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)         debug_mode <= 1'b0;
      else if (release_w) debug_mode <= ~mode_sel_in;
   end

   // R10: requests during the drive leave the cause untouched
   p_cause_hold_r10: assert property (@(posedge clk) disable iff (!por_n)
      pin_drive_low |=> $stable(rst_cause));

   // R9: captured mode holds while the system runs
   p_mode_hold_r9: assert property (@(posedge clk) disable iff (!por_n)
      ($past(!sys_rst) && !sys_rst) |-> $stable(debug_mode));
endmodule

// File: tb/rstseq_top_tb.sv
`timescale 1ns/1ps
module rstseq_top_tb;
   localparam int D = 34;
   localparam int S = 38;
   localparam int SY = 2;

   logic       clk = 1'b0;
   logic       por_n = 1'b0;
   logic       lvd = 1'b0, wdog = 1'b0, ext_hold = 1'b0, mode_sel = 1'b1;
   logic       drive_low, sys_rst, debug_mode;
   logic [3:0] cause;
   logic       pin_in;
   int         n_checks = 0, n_err = 0;

   assign pin_in = ~(drive_low | ext_hold);

   always #2.5 clk = ~clk;

   rstseq_top #(.DRIVE_CYC(D), .SAMPLE_CYC(S), .SYNC_STAGES(SY)) u_dut (
      .clk(clk), .por_n(por_n), .lvd_req(lvd), .wdog_req(wdog),
      .pin_in(pin_in), .mode_sel_in(mode_sel),
      .pin_drive_low(drive_low), .sys_rst(sys_rst),
      .rst_cause(cause), .debug_mode(debug_mode));

   function automatic logic [3:0] exp_cause(input logic l, input logic w, input logic e);
      if (l) return 4'b0010;
      if (w) return 4'b0100;
      if (e) return 4'b1000;
      return 4'b0001;
   endfunction

   function automatic int exp_release_len();
      return S + 1;
   endfunction

   task automatic check(input logic ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Called at a negedge where drive_low is already high.
   task automatic measure(output int dl, output int rl);
      dl = 0;
      while (drive_low && dl < 1000) begin dl++; @(negedge clk); end
      rl = 0;
      while (sys_rst && rl < 2000) begin rl++; @(negedge clk); end
   endtask

   task automatic internal_seq(input logic l, input logic w, input logic m, input string tag);
      int dl, rl;
      mode_sel = m;
      lvd = l; wdog = w;
      @(negedge clk);
      lvd = 0; wdog = 0;
      check(drive_low == 1'b1, {tag, " R3 start"}, int'(drive_low), 1);
      measure(dl, rl);
      check(dl == D, {tag, " R1 drive len"}, dl, D);
      check(rl == exp_release_len(), {tag, " R2 R8 release len"}, rl, exp_release_len());
      check(cause == exp_cause(l, w, 1'b0), {tag, " R5 R6 cause"}, int'(cause), int'(exp_cause(l, w, 1'b0)));
      check(debug_mode == ~m, {tag, " R9 mode"}, int'(debug_mode), int'(~m));
      repeat (3) @(negedge clk);
   endtask

   task automatic external_seq(input logic m, input string tag);
      int dl, rl;
      mode_sel = m;
      ext_hold = 1;
      @(negedge clk);
      @(negedge clk);
      check(drive_low == 1'b0 && sys_rst == 1'b0, {tag, " R4 sync latency early"}, int'(drive_low), 0);
      @(negedge clk);
      check(drive_low == 1'b1, {tag, " R4 sync latency"}, int'(drive_low), 1);
      ext_hold = 0;
      measure(dl, rl);
      check(dl == D, {tag, " R1 drive len"}, dl, D);
      check(rl == exp_release_len(), {tag, " R2 release len"}, rl, exp_release_len());
      check(cause == exp_cause(1'b0, 1'b0, 1'b1), {tag, " R4 cause pin"}, int'(cause), 8);
      check(debug_mode == ~m, {tag, " R9 mode"}, int'(debug_mode), int'(~m));
      repeat (3) @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_checks++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
   end

   initial begin : main
      int dl, rl, cnt;
      int unsigned r;
      logic dm_before;
      r = $urandom(32'd4242);

      // R11: reset values
      repeat (3) @(negedge clk);
      check(drive_low == 1'b1 && sys_rst == 1'b1, "R11 reset drive/sysrst", int'({drive_low, sys_rst}), 3);
      check(cause == 4'b0001, "R11 reset cause", int'(cause), 1);
      check(debug_mode == 1'b0, "R11 reset mode", int'(debug_mode), 0);

      // Power-on sequence, mode low -> debug
      mode_sel = 1'b0;
      por_n = 1'b1;
      #1;
      measure(dl, rl);
      check(dl == D, "R1 por drive len", dl, D);
      check(rl == exp_release_len(), "R2 por release len", rl, exp_release_len());
      check(cause == 4'b0001, "R5 por cause", int'(cause), 1);
      check(debug_mode == 1'b1, "R9 por mode debug", int'(debug_mode), 1);

      // R9: mode changes while running are ignored
      dm_before = debug_mode;
      mode_sel = 1'b1;
      repeat (5) @(negedge clk);
      check(debug_mode == dm_before, "R9 mode ignored while running", int'(debug_mode), int'(dm_before));
      check(sys_rst == 1'b0, "R8 idle no reset", int'(sys_rst), 0);

      // Directed
      internal_seq(1'b1, 1'b0, 1'b1, "lvd");
      internal_seq(1'b0, 1'b1, 1'b0, "wdog");
      internal_seq(1'b1, 1'b1, 1'b1, "R6 lvd+wdog");
      external_seq(1'b1, "ext");

      // R6: watchdog and synchronized pin on the same edge
      ext_hold = 1;
      @(negedge clk);
      @(negedge clk);
      wdog = 1;
      @(negedge clk);
      wdog = 0; ext_hold = 0;
      measure(dl, rl);
      check(cause == exp_cause(1'b0, 1'b1, 1'b1), "R6 wdog over pin", int'(cause), 4);
      repeat (3) @(negedge clk);

      // R10: watchdog and pin requests during the sequence are ignored
      lvd = 1;
      @(negedge clk);
      lvd = 0;
      fork
         measure(dl, rl);
         begin
            wdog = 1;
            repeat (D + 6) @(negedge clk);
            wdog = 0;
         end
      join
      check(dl == D, "R10 drive len unchanged", dl, D);
      check(rl == exp_release_len(), "R10 release len unchanged", rl, exp_release_len());
      check(cause == 4'b0010, "R10 cause unchanged", int'(cause), 2);
      repeat (3) @(negedge clk);

      // R7: external hold past the sample
      lvd = 1;
      @(negedge clk);
      lvd = 0;
      ext_hold = 1;
      dl = 0;
      while (drive_low && dl < 1000) begin dl++; @(negedge clk); end
      check(dl == D, "R7 drive len", dl, D);
      repeat (2 * S + 5) @(negedge clk);
      check(sys_rst == 1'b1, "R7 stays in reset", int'(sys_rst), 1);
      check(cause == 4'b1000, "R7 cause marked pin", int'(cause), 8);
      ext_hold = 0;
      cnt = 0;
      while (sys_rst && cnt < 1000) begin cnt++; @(negedge clk); end
      check(cnt >= 1 && cnt <= S + SY + 2, "R7 resample release", cnt, S + SY + 2);
      check(cause == 4'b1000, "R7 final cause", int'(cause), 8);
      repeat (3) @(negedge clk);

      // Random mix
      for (int i = 0; i < 10; i++) begin
         logic l, w, m;
         r = $urandom;
         l = r[0]; w = r[1]; m = r[2];
         if (l || w) internal_seq(l, w, m, "rand int");
         else        external_seq(m, "rand ext");
      end

      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
   end
endmodule